// File: doc/BRIEF.md
# Latency-Jitter Single-Bit Synchronizer

This block brings one asynchronous bit into a receive clock domain through a chain of flip-flops. It can also reproduce, at cycle level, the timing uncertainty that real metastability causes in hardware. An RTL simulation treats every sampling edge as clean. A real first flop that catches a changing input can instead resolve to the old value or to the new one. This block models that outcome. Each input change may reach the output one receive cycle later than an ideal synchronizer would deliver it, one cycle earlier, or on time. The choice comes from a pseudo-random sequence that the seed fixes, so any run can be repeated exactly.

The block is meant for simulation regressions of logic that sits downstream and combines several separately synchronized signals. With injection turned off it behaves exactly like a plain flop chain. With injection on, the latency of each transition moves by at most one cycle in either direction, and the delivered value never changes. A one-cycle event strobe and an outcome code show each shift, so that a failure further downstream can be traced back to the shift that caused it.

Top module: `meta_inject_sync`

## Requirements
- R1: The chain is SYNC_DEPTH flops long, with SYNC_DEPTH at least 2. While injectEn is 0, syncOut equals the asyncIn value sampled SYNC_DEPTH rising edges earlier.
- R2: Reset is synchronous and active high. It clears every chain flop, syncOut, injEvent and injCode (00), and it loads the pseudo-random state from seedVal. An all-zero seedVal is replaced by 1.
- R3: An edge counts as a transition edge when asyncIn differs from the value held in the first chain flop. An injection can happen only on a transition edge while injectEn is 1.
- R4: The pseudo-random state is a 16-bit Galois LFSR. It steps on every edge that is not a reset edge: the state shifts right by one, and if the old bit 0 was 1 it is XORed with 0xB400. Each decision uses the state before the step. Bits [1:0] = 01 choose delay, 10 choose advance, and 00 or 11 choose no change.
- R5: A delay keeps the old value in the first flop for one more edge. The edge right after a delay is never injected, so one transition is delayed by one cycle at most.
- R6: An advance loads asyncIn directly into the second flop, one cycle early. It is allowed only when the first and second flops hold equal values. Otherwise the edge gets no change.
- R7: injEvent is high for the one cycle after an injected edge. injCode is 01 after a delay, 10 after an advance, and 00 in every other cycle.
- R8: An asyncIn value held steady for SYNC_DEPTH+1 edges appears on syncOut, whatever the injection setting.
- R9: While injectEn is 0, injEvent stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| asyncIn | input | 1 | Asynchronous input bit |
| injectEn | input | 1 | Enables latency injection |
| seedVal | input | 16 | LFSR seed, loaded during reset |
| syncOut | output | 1 | Synchronized bit |
| injEvent | output | 1 | One-cycle strobe after an injected edge |
| injCode | output | 2 | 01 delayed, 10 advanced, 00 none |

## Verification
The hard cases are those where an injection decision falls in the same cycle as an earlier transition that is still moving through the chain. One case is an advance requested while the first two flops still disagree. The other is a new transition arriving on the edge right after a delay. The bench provokes both by toggling the input every cycle and every second cycle, repeated across several seeds. It judges every cycle against an arithmetic model of the requirements, comparing syncOut, injEvent and injCode. Slower toggle periods and long holds confirm the plain latency and that the value is always delivered.

// File: rtl/meta_sync_pkg.sv
package meta_sync_pkg;

  typedef struct packed {
    logic holdFirst;
    logic skipFirst;
  } chainStrobe_t;

  typedef enum logic [1:0] {
    INJ_NONE    = 2'b00,
    INJ_DELAY   = 2'b01,
    INJ_ADVANCE = 2'b10
  } injCode_e;

  localparam logic [1:0] PICK_DELAY   = 2'b01;
  localparam logic [1:0] PICK_ADVANCE = 2'b10;

endpackage

// File: rtl/msync_lfsr.sv
module msync_lfsr #(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LFSR_W-1:0] seed,
  output logic [LFSR_W-1:0] state
);

  localparam logic [LFSR_W-1:0] ONE = {{(LFSR_W-1){1'b0}}, 1'b1};

  logic [LFSR_W-1:0] nextState;

  always_comb begin
    nextState = {1'b0, state[LFSR_W-1:1]};
    if (state[0]) nextState = nextState ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= (seed == '0) ? ONE : seed;
    else     state <= nextState;
  end

  // R4: the sequence never collapses to the all-zero lockup state
  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    state != '0);

endmodule

// File: rtl/msync_chain.sv
module msync_chain
  import meta_sync_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         asyncIn,
  input  chainStrobe_t strobe,
  output logic         stage0,
  output logic         stage1,
  output logic         syncOut
);

  logic [SYNC_DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst)                  chain[0] <= 1'b0;
    else if (strobe.holdFirst) chain[0] <= chain[0];
    else                      chain[0] <= asyncIn;
  end

  always_ff @(posedge clk) begin
    if (rst)                  chain[1] <= 1'b0;
    else if (strobe.skipFirst) chain[1] <= asyncIn;
    else                      chain[1] <= chain[0];
  end

  generate
    for (genvar g = 2; g < SYNC_DEPTH; g++) begin : gTail
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign stage0  = chain[0];
  assign stage1  = chain[1];
  assign syncOut = chain[SYNC_DEPTH-1];

  // R6: an advance is only commanded when the first two flops agree
  a_r6_advance_guard: assert property (@(posedge clk) disable iff (rst)
    strobe.skipFirst |-> (chain[0] == chain[1]));

  // R5: delay and advance never requested on the same edge
  a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(strobe.holdFirst && strobe.skipFirst));

  // R5: a delayed edge leaves the first flop unchanged
  a_r5_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    strobe.holdFirst |=> (chain[0] == $past(chain[0])));

  // R1: without a hold the first flop samples the input
  a_r1_plain_sample: assert property (@(posedge clk) disable iff (rst)
    !strobe.holdFirst |=> (chain[0] == $past(asyncIn)));

endmodule

// File: rtl/msync_ctrl.sv
module msync_ctrl
  import meta_sync_pkg::*;
#(
  parameter int LFSR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              asyncIn,
  input  logic              injectEn,
  input  logic [LFSR_W-1:0] seedVal,
  input  logic              stage0,
  input  logic              stage1,
  output chainStrobe_t      strobe,
  output logic              injEvent,
  output injCode_e          injCode
);

  logic [LFSR_W-1:0] lfsrState;
  logic              afterDelay;
  logic              transEdge;
  logic              eligible;
  logic [1:0]        pick;
  logic              wantDelay;
  logic              wantAdvance;

  msync_lfsr #(.LFSR_W(LFSR_W)) uLfsr (
    .clk   (clk),
    .rst   (rst),
    .seed  (seedVal),
    .state (lfsrState)
  );

  always_comb begin
    transEdge   = (asyncIn != stage0);
    eligible    = injectEn && transEdge && !afterDelay;
    pick        = lfsrState[1:0];
    wantDelay   = eligible && (pick == PICK_DELAY);
    wantAdvance = eligible && (pick == PICK_ADVANCE) && (stage0 == stage1);
    strobe.holdFirst = wantDelay;
    strobe.skipFirst = wantAdvance;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      afterDelay <= 1'b0;
      injEvent   <= 1'b0;
      injCode    <= INJ_NONE;
    end else begin
      afterDelay <= wantDelay;
      injEvent   <= wantDelay || wantAdvance;
      if (wantDelay)        injCode <= INJ_DELAY;
      else if (wantAdvance) injCode <= INJ_ADVANCE;
      else                  injCode <= INJ_NONE;
    end
  end

  // R7: a pulse always carries a real outcome code
  a_r7_event_has_code: assert property (@(posedge clk) disable iff (rst)
    injEvent |-> (injCode != INJ_NONE));

  // R7: no code without a pulse
  a_r7_quiet_code: assert property (@(posedge clk) disable iff (rst)
    !injEvent |-> (injCode == INJ_NONE));

  // R9: disabled injection never reports an event
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !injectEn |=> !injEvent);

  // R5: two delays never follow one another
  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (injEvent && injCode == INJ_DELAY) |=> !(injEvent && injCode == INJ_DELAY));

  // R3: an event only follows a transition edge
  a_r3_event_needs_change: assert property (@(posedge clk) disable iff (rst)
    strobe.holdFirst |=> (injEvent && $past(asyncIn) != $past(stage0)));

endmodule

// File: rtl/meta_inject_sync.sv
module meta_inject_sync
  import meta_sync_pkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int LFSR_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              asyncIn,
  input  logic              injectEn,
  input  logic [LFSR_W-1:0] seedVal,
  output logic              syncOut,
  output logic              injEvent,
  output logic [1:0]        injCode
);

  generate
    if (SYNC_DEPTH < 2) begin : gBadDepth
      initial $error("SYNC_DEPTH must be at least 2");
    end
  endgenerate

  chainStrobe_t strobe;
  logic         stage0;
  logic         stage1;
  injCode_e     codeInt;

  msync_ctrl #(.LFSR_W(LFSR_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .asyncIn  (asyncIn),
    .injectEn (injectEn),
    .seedVal  (seedVal),
    .stage0   (stage0),
    .stage1   (stage1),
    .strobe   (strobe),
    .injEvent (injEvent),
    .injCode  (codeInt)
  );

  msync_chain #(.SYNC_DEPTH(SYNC_DEPTH)) uChain (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (asyncIn),
    .strobe  (strobe),
    .stage0  (stage0),
    .stage1  (stage1),
    .syncOut (syncOut)
  );

  assign injCode = codeInt;

  // R2: reset leaves output and status quiet on the following cycle
  a_r2_reset_clear: assert property (@(posedge clk)
    rst |=> (!syncOut && !injEvent && injCode == 2'b00));

endmodule

// File: tb/sim_meta_inject_sync.sv
module sim_meta_inject_sync;

  localparam int D = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        asyncIn = 1'b0;
  logic        injectEn = 1'b0;
  logic [15:0] seedVal = 16'h0001;
  logic        syncOut;
  logic        injEvent;
  logic [1:0]  injCode;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  meta_inject_sync #(.SYNC_DEPTH(D), .LFSR_W(16)) u0 (
    .clk(clk), .rst(rst), .asyncIn(asyncIn), .injectEn(injectEn),
    .seedVal(seedVal), .syncOut(syncOut), .injEvent(injEvent), .injCode(injCode)
  );

  // independent model state
  bit        m [D];
  bit        idealHist [D];
  bit [15:0] mL;
  bit        mAfter;
  bit        mEv;
  bit [1:0]  mCode;
  bit        prevWasDelay;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit rstV, input bit inV, input bit enV, input bit cmpIdeal);
    bit trans, elig, dly, adv, n0, n1;
    @(negedge clk);
    rst = rstV; asyncIn = inV; injectEn = enV;
    @(posedge clk);
    #5;
    if (rstV) begin
      for (int i = 0; i < D; i++) begin m[i] = 0; idealHist[i] = 0; end
      mL = (seedVal == 16'h0) ? 16'h1 : seedVal;
      mAfter = 0; mEv = 0; mCode = 0;
    end else begin
      trans = (inV != m[0]);
      elig  = enV && trans && !mAfter;
      dly   = elig && (mL[1:0] == 2'b01);
      adv   = elig && (mL[1:0] == 2'b10) && (m[0] == m[1]);
      n0 = dly ? m[0] : inV;
      n1 = adv ? inV : m[0];
      for (int i = D-1; i >= 2; i--) m[i] = m[i-1];
      m[1] = n1; m[0] = n0;
      for (int i = D-1; i >= 1; i--) idealHist[i] = idealHist[i-1];
      idealHist[0] = inV;
      mL = {1'b0, mL[15:1]} ^ (mL[0] ? 16'hB400 : 16'h0);
      mAfter = dly; mEv = dly | adv; mCode = dly ? 2'b01 : (adv ? 2'b10 : 2'b00);
    end
    if (cmpIdeal) begin
      check(syncOut == idealHist[D-1], "R1 ideal latency", syncOut, idealHist[D-1]);
      check(injEvent == 1'b0, "R9 no event when disabled", injEvent, 0);
    end else begin
      check(syncOut == m[D-1], "R5/R6 output timing", syncOut, m[D-1]);
      check(injEvent == mEv, "R3/R4 event decision", injEvent, mEv);
      check(injCode == mCode, "R7 outcome code", injCode, mCode);
    end
    // R5: two delay events never in consecutive cycles
    if (injEvent && injCode == 2'b01 && prevWasDelay)
      check(1'b0, "R5 back-to-back delay", 1, 0);
    prevWasDelay = injEvent && injCode == 2'b01;
  endtask

  task automatic doReset();
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    bit [15:0] seeds [5] = '{16'h0001, 16'hACE1, 16'h0000, 16'h8000, 16'h1234};
    bit v;
    prevWasDelay = 0;
    for (int s = 0; s < 5; s++) begin
      seedVal = seeds[s];
      doReset();
      // R2: reset state
      check(syncOut == 1'b0, "R2 reset output", syncOut, 0);
      check(injEvent == 1'b0, "R2 reset event", injEvent, 0);
      check(injCode == 2'b00, "R2 reset code", injCode, 0);
      // injection enabled: toggle periods 1..6
      for (int p = 1; p <= 6; p++) begin
        v = 0;
        for (int c = 0; c < 60; c++) begin
          if (c % p == 0) v = ~v;
          tick(1'b0, v, 1'b1, 1'b0);
        end
        // R8: hold steady and confirm delivery
        for (int h = 0; h < D + 1; h++) tick(1'b0, v, 1'b1, 1'b0);
        check(syncOut == v, "R8 steady value delivered", syncOut, v);
      end
      // injection disabled: ideal chain
      doReset();
      for (int p = 1; p <= 6; p++) begin
        v = 0;
        for (int c = 0; c < 60; c++) begin
          if ((c + p) % p == 0) v = ~v;
          tick(1'b0, v, 1'b0, 1'b1);
        end
        for (int h = 0; h < D + 1; h++) tick(1'b0, v, 1'b0, 1'b1);
        check(syncOut == v, "R8 steady value delivered, disabled", syncOut, v);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule